// File: doc/BRIEF.md
# Mirrored Memory Decoder with Fetch Steering

This block turns the top three address bits and the bus cycle strobes of an 8-bit processor into active-low chip selects for one 8 KB ROM and four 8 KB RAM banks. The 64 KB space is cut into eight 8 KB regions. The lower half maps the ROM and RAM banks 1 to 3. The upper half repeats RAM banks 1 to 3, so display fetches that run with the top address bit set still reach the same memory.

One upper region is split by cycle type. An opcode fetch there reads the ROM, and any data read or write there goes to RAM bank 0. Two veto inputs let a peripheral take over part of the space. One veto holds the ROM quiet and the other holds every RAM bank quiet.

No select is driven unless the cycle is a real memory access. The decoder is purely combinational and holds no state.

Top module: `mirror_mem_decoder`

## Requirements
- R1: Region code 0 (addr_hi = 3'd0) asserts rom_sel_n low on any memory access, fetch or data.
- R2: Region codes 1, 2 and 3 assert ram_sel_n[1], ram_sel_n[2] and ram_sel_n[3] low respectively.
- R3: Region code 4 with m1_n low (opcode fetch) asserts rom_sel_n low.
- R4: Region code 4 with m1_n high asserts ram_sel_n[0] low.
- R5: Region codes 5, 6 and 7 mirror banks 1, 2 and 3: they assert ram_sel_n[1], ram_sel_n[2] and ram_sel_n[3] low respectively.
- R6: While mreq_n is high, rom_sel_n and all ram_sel_n bits are high.
- R7: While rfsh_n is low (refresh cycle), rom_sel_n and all ram_sel_n bits are high.
- R8: rom_veto high forces rom_sel_n high and has no effect on the RAM selects.
- R9: ram_veto high forces all ram_sel_n bits high and has no effect on rom_sel_n.
- R10: At most one of the five select outputs is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_hi | input | 3 | Address bits 15..13 (region code) |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| m1_n | input | 1 | Opcode fetch marker, active low |
| rom_veto | input | 1 | High forces the ROM select inactive |
| ram_veto | input | 1 | High forces all RAM selects inactive |
| rom_sel_n | output | 1 | ROM chip select, active low |
| ram_sel_n | output | 4 | RAM bank chip selects, active low, bit index = bank |

## Verification
The assertions check on every evaluation that the outputs stay quiet when there is no request or a refresh is running, that each veto silences its own selects, that no two selects are active together, and that fetches in region 0 and in the split region land on the ROM. The assertions cannot show that each region reaches the correct bank number, that the upper mirrors match their lower partners, or that a veto leaves the other device alone. The bench shows these by sweeping every combination of region, strobes and vetoes against its reference map.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
   localparam int REGION_W = 3;
   localparam int BANK_W   = 2;
   localparam int NUM_BANKS = 1 << BANK_W;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_ROM  = 2'd1,
      TGT_RAM  = 2'd2
   } target_e;

   typedef struct packed {
      target_e            tgt;
      logic [BANK_W-1:0]  bank;
   } route_t;
endpackage

// File: rtl/memdec_cycle_qual.sv
// Decides whether the current bus cycle is a genuine memory access.
module memdec_cycle_qual (
   input  logic mreq_n,
   input  logic rfsh_n,
   output logic mem_cycle
);
   always_comb begin
      mem_cycle = 1'b0;
      if (!mreq_n && rfsh_n) mem_cycle = 1'b1;
   end
endmodule

// File: rtl/memdec_region_map.sv
// Maps a region code and the fetch marker onto a target device and bank.
module memdec_region_map
   import memdec_pkg::*;
#(
   parameter int REGION_W     = memdec_pkg::REGION_W,
   parameter int STEER_REGION = 4,
   parameter bit STEER_EN     = 1'b1
) (
   input  logic [REGION_W-1:0] region,
   input  logic                m1_n,
   output route_t              route
);
   localparam int REGIONS = 1 << REGION_W;

   logic fetch;
   logic [BANK_W-1:0] mirror_bank;

   assign fetch       = ~m1_n;
   assign mirror_bank = region[BANK_W-1:0];

   generate
      if (STEER_EN) begin : g_steer
         always_comb begin
            route.tgt  = TGT_RAM;
            route.bank = mirror_bank;
            if (region == '0) begin
               route.tgt  = TGT_ROM;
               route.bank = '0;
            end else if (int'(region) == STEER_REGION && fetch) begin
               route.tgt  = TGT_ROM;
               route.bank = '0;
            end
         end
      end else begin : g_plain
         always_comb begin
            route.tgt  = TGT_RAM;
            route.bank = mirror_bank;
            if (region == '0) begin
               route.tgt  = TGT_ROM;
               route.bank = '0;
            end
         end
      end
   endgenerate

   if (STEER_REGION <= 0 || STEER_REGION >= REGIONS) begin : g_bad_steer
      $error("steer region must be a nonzero region code");
   end
endmodule

// File: rtl/memdec_select_drv.sv
// Converts a route into active-low selects and applies the vetoes.
module memdec_select_drv
   import memdec_pkg::*;
#(
   parameter int BANKS = memdec_pkg::NUM_BANKS
) (
   input  route_t           route,
   input  logic             mem_cycle,
   input  logic             rom_veto,
   input  logic             ram_veto,
   output logic             rom_sel_n,
   output logic [BANKS-1:0] ram_sel_n
);
   logic rom_hit;
   logic ram_hit;

   assign rom_hit   = mem_cycle && (route.tgt == TGT_ROM) && !rom_veto;
   assign ram_hit   = mem_cycle && (route.tgt == TGT_RAM) && !ram_veto;
   assign rom_sel_n = ~rom_hit;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign ram_sel_n[b] = ~(ram_hit && (int'(route.bank) == b));
   end
endmodule

// File: rtl/mirror_mem_decoder.sv
module mirror_mem_decoder
   import memdec_pkg::*;
#(
   parameter int ADDR_HI_W    = memdec_pkg::REGION_W,
   parameter int RAM_BANKS    = memdec_pkg::NUM_BANKS,
   parameter int STEER_REGION = 4,
   parameter bit STEER_EN     = 1'b1
) (
   input  logic [ADDR_HI_W-1:0] addr_hi,
   input  logic                 mreq_n,
   input  logic                 rfsh_n,
   input  logic                 m1_n,
   input  logic                 rom_veto,
   input  logic                 ram_veto,
   output logic                 rom_sel_n,
   output logic [RAM_BANKS-1:0] ram_sel_n
);
   if (ADDR_HI_W != memdec_pkg::REGION_W) begin : g_bad_width
      $error("region code width must match the package");
   end
   if (RAM_BANKS != (1 << (ADDR_HI_W - 1))) begin : g_bad_banks
      $error("bank count must equal half the region count");
   end

   logic   mem_cycle;
   route_t route;

   memdec_cycle_qual i_qual (
      .mreq_n    (mreq_n),
      .rfsh_n    (rfsh_n),
      .mem_cycle (mem_cycle)
   );

   memdec_region_map #(
      .REGION_W     (ADDR_HI_W),
      .STEER_REGION (STEER_REGION),
      .STEER_EN     (STEER_EN)
   ) i_map (
      .region (addr_hi),
      .m1_n   (m1_n),
      .route  (route)
   );

   memdec_select_drv #(
      .BANKS (RAM_BANKS)
   ) i_drv (
      .route     (route),
      .mem_cycle (mem_cycle),
      .rom_veto  (rom_veto),
      .ram_veto  (ram_veto),
      .rom_sel_n (rom_sel_n),
      .ram_sel_n (ram_sel_n)
   );
endmodule

// File: rtl/memdec_checker.sv
module memdec_checker #(
   parameter int ADDR_HI_W = 3,
   parameter int RAM_BANKS = 4
) (
   input logic [ADDR_HI_W-1:0] addr_hi,
   input logic                 mreq_n,
   input logic                 rfsh_n,
   input logic                 m1_n,
   input logic                 rom_veto,
   input logic                 ram_veto,
   input logic                 rom_sel_n,
   input logic [RAM_BANKS-1:0] ram_sel_n
);
   always_comb begin
      if (mreq_n) AST_IDLE_QUIET: assert (rom_sel_n && (&ram_sel_n)); // R6
      if (!rfsh_n) AST_REFRESH_QUIET: assert (rom_sel_n && (&ram_sel_n)); // R7
      if (rom_veto) AST_ROM_VETO: assert (rom_sel_n); // R8
      if (ram_veto) AST_RAM_VETO: assert (&ram_sel_n); // R9
      AST_SINGLE_SELECT: assert ($countones({~rom_sel_n, ~ram_sel_n}) <= 1); // R10
      if (addr_hi == 3'd4 && !m1_n && !mreq_n && rfsh_n && !rom_veto)
         AST_FETCH_STEER: assert (!rom_sel_n); // R3
      if (addr_hi == 3'd0 && !mreq_n && rfsh_n && !rom_veto)
         AST_LOW_ROM: assert (!rom_sel_n); // R1
   end
endmodule

bind mirror_mem_decoder memdec_checker #(
   .ADDR_HI_W (ADDR_HI_W),
   .RAM_BANKS (RAM_BANKS)
) i_chk (
   .addr_hi   (addr_hi),
   .mreq_n    (mreq_n),
   .rfsh_n    (rfsh_n),
   .m1_n      (m1_n),
   .rom_veto  (rom_veto),
   .ram_veto  (ram_veto),
   .rom_sel_n (rom_sel_n),
   .ram_sel_n (ram_sel_n)
);

// File: tb/test_mirror_mem_decoder.sv
module test_mirror_mem_decoder;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] addr_hi = '0;
   logic       mreq_n = 1'b1;
   logic       rfsh_n = 1'b1;
   logic       m1_n = 1'b1;
   logic       rom_veto = 1'b0;
   logic       ram_veto = 1'b0;
   logic       rom_sel_n;
   logic [3:0] ram_sel_n;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mirror_mem_decoder i_mirror_mem_decoder (
      .addr_hi   (addr_hi),
      .mreq_n    (mreq_n),
      .rfsh_n    (rfsh_n),
      .m1_n      (m1_n),
      .rom_veto  (rom_veto),
      .ram_veto  (ram_veto),
      .rom_sel_n (rom_sel_n),
      .ram_sel_n (ram_sel_n)
   );

   // Reference: returns {rom_sel_n, ram_sel_n[3:0]}.
   function automatic logic [4:0] ref_model(int a, bit mq, bit rf, bit m1, bit rv, bit av);
      int dev;            // -1 none, 4 rom, 0..3 ram bank
      logic [4:0] r;
      r = 5'b11111;
      dev = -1;
      if (!mq && rf) begin
         case (a)
            0: dev = 4;
            1, 5: dev = 1;
            2, 6: dev = 2;
            3, 7: dev = 3;
            4: dev = m1 ? 0 : 4;
            default: dev = -1;
         endcase
      end
      if (dev == 4 && !rv) r[4] = 1'b0;
      if (dev >= 0 && dev < 4 && !av) r[dev] = 1'b0;
      return r;
   endfunction

   function automatic string req_of(int a, bit mq, bit rf, bit m1, bit rv, bit av);
      if (!rf) return "R7";
      if (mq) return "R6";
      if ((a == 0 || (a == 4 && !m1)) && rv) return "R8";
      if (!(a == 0 || (a == 4 && !m1)) && av) return "R9";
      if (a == 0) return "R1";
      if (a == 4) return m1 ? "R4" : "R3";
      if (a < 4) return "R2";
      return "R5";
   endfunction

   task automatic check(string tag, logic [4:0] exp);
      logic [4:0] act;
      act = {rom_sel_n, ram_sel_n};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s addr=%0d mreq_n=%b rfsh_n=%b m1_n=%b rv=%b av=%b actual=%b expected=%b",
                  tag, addr_hi, mreq_n, rfsh_n, m1_n, rom_veto, ram_veto, act, exp);
      end
      if ($countones(~act) > 1) begin
         total++;
         bad++;
         $display("FAIL R10 several selects active actual=%b expected=at most one low", act);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      // Reset state: no request, everything quiet (R6)
      @(negedge clk);
      check("R6", 5'b11111);
      rst = 1'b0;
      // Exhaustive sweep, one combination per clock
      for (int v = 0; v < 256; v++) begin
         @(posedge clk);
         #1;
         addr_hi  = v[2:0];
         mreq_n   = v[3];
         rfsh_n   = ~v[4];
         m1_n     = v[5];
         rom_veto = v[6];
         ram_veto = v[7];
         @(negedge clk);
         check(req_of(v % 8, v[3], ~v[4], v[5], v[6], v[7]),
               ref_model(v % 8, v[3], ~v[4], v[5], v[6], v[7]));
      end
      // Directed: R8 veto leaves RAM alone, R9 veto leaves ROM alone
      @(posedge clk); #1;
      addr_hi = 3'd6; mreq_n = 1'b0; rfsh_n = 1'b1; m1_n = 1'b1; rom_veto = 1'b1; ram_veto = 1'b0;
      @(negedge clk); check("R8", 5'b11011);
      @(posedge clk); #1;
      addr_hi = 3'd4; m1_n = 1'b0; rom_veto = 1'b0; ram_veto = 1'b1;
      @(negedge clk); check("R9", 5'b01111);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule